// File: doc/BRIEF.md
# Two-Contact Switch Debouncer

This block cleans up changeover (single-pole double-throw) switches whose normally-open and normally-closed contacts both reach the chip as separate asynchronous, active-high inputs. A contact reads high only while the blade rests on it. While the blade is travelling or bouncing between contacts, both inputs read low. Each channel brings its two contact lines into the system clock domain through a two-flop synchronizer. A set/clear state register then follows the blade. The open contact makes the state pressed, and the closed contact makes it released. When neither contact is touched, the state does not change. No timer is involved, so a press is recognised on the first touch of the open contact.

Per channel the block drives a registered debounced level, a one-clock press strobe, a one-clock release strobe and a sticky fault flag. The fault flag records that both contacts were seen high together, which a working switch cannot produce. The channel count is a parameter, and every channel is fully independent. A release is recognised only when the blade arrives back on the closed contact. The release latency therefore includes the blade's return travel.

Top module: `spdt_debounce`

## Requirements
- R1: A high level on a channel's open contact, with its closed contact low, makes that channel's level output 1.
- R2: A high level on a channel's closed contact makes that channel's level output 0.
- R3: While both contacts of a channel are low, its level output keeps its previous value.
- R4: When both contacts of a channel are high together, the closed contact wins: the level becomes 0, and no press strobe is produced.
- R5: The fault output of a channel goes to 1 when both of its contacts are high together. It then stays at 1 until the reset input is applied.
- R6: While the synchronous active-high reset is applied, every level, press, release and fault output is 0.
- R7: The press output is 1 for exactly one clock, in the same cycle in which the level output changes from 0 to 1.
- R8: The release output is 1 for exactly one clock, in the same cycle in which the level output changes from 1 to 0.
- R9: Once a channel is pressed, further bounces on its open contact (low/high repeats with the closed contact low) leave the level at 1 and produce no further press strobe. The same holds for closed-contact bounces while the channel is released.
- R10: A contact change that is set up before a clock edge appears on the level output after the third rising edge. It is not yet visible after the second edge.
- R11: Channels are independent: activity on one channel never changes the outputs of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_open_i | input | CHANNELS | Normally-open contact per channel, asynchronous, high when touched |
| sw_closed_i | input | CHANNELS | Normally-closed contact per channel, asynchronous, high when touched |
| level_o | output | CHANNELS | Debounced switch state, 1 = pressed |
| press_o | output | CHANNELS | One-clock strobe on a released-to-pressed change |
| release_o | output | CHANNELS | One-clock strobe on a pressed-to-released change |
| fault_o | output | CHANNELS | Sticky flag: both contacts were seen high together |

## Verification
The release strobe and the fault flag can rise in the same cycle. This happens when a pressed channel sees its closed contact go high while the open contact is still high. The bench holds the open contact of a pressed channel high, raises the closed contact, and counts three edges. It then expects the level at 0, a release strobe and a raised fault flag together. It also expects no press strobe, and no fault on the other channel. The flag must then outlast the removal of the conflict, and it must be cleared only by reset.

// File: rtl/spdt_pkg.sv
package spdt_pkg;

  // Number of flops between an asynchronous contact and the state logic.
  localparam int unsigned SYNC_DEPTH = 2;

  // Per-channel registered result of the state cell.
  typedef struct packed {
    logic level;
    logic press;
    logic release_;
    logic fault;
  } chan_out_t;

endpackage

// File: rtl/contact_sync.sv
module contact_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[LAST];

  // The output lags the previous stage by exactly one clock.
  AST_SYNC_DEPTH: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (sync_o == $past(chain[LAST-1]))); // R10

endmodule

// File: rtl/switch_state_cell.sv
module switch_state_cell
  import spdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      set_i,
  input  logic      clr_i,
  output chan_out_t out_o
);

  logic held;
  logic held_nxt;
  logic press_q;
  logic rel_q;
  logic fault_q;

  // Closed contact dominates; with no contact the state is kept.
  always_comb begin
    if (clr_i)      held_nxt = 1'b0;
    else if (set_i) held_nxt = 1'b1;
    else            held_nxt = held;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      held    <= 1'b0;
      press_q <= 1'b0;
      rel_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      held    <= held_nxt;
      press_q <= held_nxt & ~held;
      rel_q   <= ~held_nxt & held;
      fault_q <= fault_q | (set_i & clr_i);
    end
  end

  assign out_o.level    = held;
  assign out_o.press    = press_q;
  assign out_o.release_ = rel_q;
  assign out_o.fault    = fault_q;

  AST_SET_ON_OPEN: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_i) |=> out_o.level); // R1

  AST_CLEAR_ON_CLOSED: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !out_o.level); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !clr_i) |=> $stable(out_o.level)); // R3

  AST_CONFLICT_NO_PRESS: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> !out_o.press); // R4

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    out_o.fault |=> out_o.fault); // R5

  AST_FAULT_ON_CONFLICT: assert property (@(posedge clk) disable iff (rst)
    (set_i && clr_i) |=> out_o.fault); // R5

  AST_PRESS_ON_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(out_o.level) |-> out_o.press); // R7

  AST_PRESS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    out_o.press |=> !out_o.press); // R7

  AST_RELEASE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(out_o.level) |-> out_o.release_); // R8

  AST_RELEASE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    out_o.release_ |=> !out_o.release_); // R8

endmodule

// File: rtl/spdt_debounce.sv
module spdt_debounce
  import spdt_pkg::*;
#(
  parameter int unsigned CHANNELS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] sw_open_i,
  input  logic [CHANNELS-1:0] sw_closed_i,
  output logic [CHANNELS-1:0] level_o,
  output logic [CHANNELS-1:0] press_o,
  output logic [CHANNELS-1:0] release_o,
  output logic [CHANNELS-1:0] fault_o
);

  localparam int unsigned CONTACTS = 2;
  localparam int unsigned IDX_OPEN = 0;
  localparam int unsigned IDX_CLSD = 1;

  for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
    logic [CONTACTS-1:0] raw;
    logic [CONTACTS-1:0] synced;
    chan_out_t           res;

    assign raw[IDX_OPEN] = sw_open_i[c];
    assign raw[IDX_CLSD] = sw_closed_i[c];

    contact_sync #(
      .WIDTH  (CONTACTS),
      .STAGES (SYNC_DEPTH)
    ) i_sync (
      .clk     (clk),
      .rst     (rst),
      .async_i (raw),
      .sync_o  (synced)
    );

    switch_state_cell i_cell (
      .clk   (clk),
      .rst   (rst),
      .set_i (synced[IDX_OPEN]),
      .clr_i (synced[IDX_CLSD]),
      .out_o (res)
    );

    assign level_o[c]   = res.level;
    assign press_o[c]   = res.press;
    assign release_o[c] = res.release_;
    assign fault_o[c]   = res.fault;

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(press_o[c] && release_o[c])); // R7 R8
  end

endmodule

// File: tb/test_spdt_debounce.sv
module test_spdt_debounce;

  localparam int CH = 2;
  localparam int NVEC = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CH-1:0] sw_open = '0;
  logic [CH-1:0] sw_closed = '1;
  logic [CH-1:0] level, press, rel, fault;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  spdt_debounce #(.CHANNELS(CH)) i_spdt_debounce (
    .clk         (clk),
    .rst         (rst),
    .sw_open_i   (sw_open),
    .sw_closed_i (sw_closed),
    .level_o     (level),
    .press_o     (press),
    .release_o   (rel),
    .fault_o     (fault)
  );

  // {open, closed, exp_level, exp_press, exp_release} for channel 0
  localparam logic [4:0] VEC [NVEC] = '{
    5'b10_110, // R1 R7 press
    5'b00_100, // R3 hold pressed
    5'b10_100, // R9 open bounce
    5'b00_100, // R3
    5'b01_001, // R2 R8 release
    5'b00_000, // R3 hold released
    5'b01_000, // R9 closed bounce
    5'b10_110, // R1 R7
    5'b01_001, // R2 R8
    5'b00_000  // R3
  };

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    step(3);
    check("R6 level", level[0] | level[1], 1'b0);
    check("R6 press", press[0] | press[1], 1'b0);
    check("R6 release", rel[0] | rel[1], 1'b0);
    check("R6 fault", fault[0] | fault[1], 1'b0);
    rst = 1'b0;
    step(4);

    for (int i = 0; i < NVEC; i++) begin
      sw_open[0]   = VEC[i][4];
      sw_closed[0] = VEC[i][3];
      step(3);
      check("R1/R2/R3/R9 level", level[0], VEC[i][2]);
      check("R7/R9 press", press[0], VEC[i][1]);
      check("R8 release", rel[0], VEC[i][0]);
      step(1);
      check("R7 press one cycle", press[0], 1'b0);
      check("R8 release one cycle", rel[0], 1'b0);
      check("R11 other channel level", level[1], 1'b0);
    end

    // Conflict from pressed: release strobe and fault in the same cycle
    sw_open[0] = 1'b1; sw_closed[0] = 1'b0;
    step(4);
    check("R1 pressed before conflict", level[0], 1'b1);
    sw_closed[0] = 1'b1;
    step(3);
    check("R4 closed dominates", level[0], 1'b0);
    check("R4 release on conflict", rel[0], 1'b1);
    check("R4 no press on conflict", press[0], 1'b0);
    check("R5 fault raised", fault[0], 1'b1);
    check("R11 fault isolated", fault[1], 1'b0);
    sw_open[0] = 1'b0;
    step(4);
    check("R5 fault sticky", fault[0], 1'b1);

    // Conflict from released: no press strobe
    sw_open[0] = 1'b1;
    step(3);
    check("R4 no press from released", press[0], 1'b0);
    check("R4 level stays 0", level[0], 1'b0);
    sw_open[0] = 1'b0;
    step(2);

    // Latency on channel 1
    sw_open[1] = 1'b1; sw_closed[1] = 1'b0;
    step(2);
    check("R10 not after two edges", level[1], 1'b0);
    step(1);
    check("R10 after three edges", level[1], 1'b1);
    check("R10 press with level", press[1], 1'b1);
    check("R11 channel 0 untouched", level[0] | press[0], 1'b0);

    // Reset clears sticky fault
    rst = 1'b1;
    step(1);
    check("R5 fault cleared by reset", fault[0], 1'b0);
    check("R6 level cleared by reset", level[1], 1'b0);
    rst = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule